// File: doc/BRIEF.md
# USB Control Endpoint Setup-Stage Handler

This block sits behind the serial interface engine of a USB device and owns the SETUP stage of the control endpoint. Received data bytes arrive as a stream with a valid strobe, framed by a start-of-packet strobe and an end-of-packet strobe. The end-of-packet cycle carries two verdicts from the engine: whether the received CRC matched the computed one, and whether the data toggle was as expected. The block collects the eight request bytes in a shadow buffer. At end of packet it either accepts the request or stays silent so that the host retries.

On acceptance it copies the request into five field registers and issues a one-cycle ACK request. It moves the stage status to DATAIN and sets the data toggle to 1. From the accepted request it derives the transfer type (read, write, or write without a data stage) and whether the request can be completed in hardware. Software-owned requests raise a one-cycle setup interrupt, which is also held in a sticky flag until firmware clears it.

Top module: `usb_setup_stage`

## Requirements
- R1: After reset the stage status is IDLE (code 0), the data toggle is 0, every field register is 0, and ack_req, setup_irq and setup_irq_flag are low.
- R2: After an accepted request the field registers hold it: req_type is byte 0 and req_code is byte 1. req_value is bytes 2 (low) and 3 (high), req_index is bytes 4 (low) and 5 (high), and req_length is bytes 6 (low) and 7 (high). They are visible in the cycle after the end-of-packet strobe.
- R3: A packet with exactly 8 data bytes whose end-of-packet cycle shows both CRC match and toggle match gives ack_req high for exactly the one cycle after end of packet.
- R4: If the CRC or toggle flag is low at end of packet, the stage status becomes RX_ERR (code 2). No ACK or interrupt is issued, and the field registers keep their previous contents.
- R5: A packet with fewer or more than 8 data bytes is handled as in R4, even with both flags high.
- R6: An accepted request sets the stage status to DATAIN (code 1) and the data toggle to 1. A rejected one leaves the toggle unchanged.
- R7: xfer_kind is 0 when req_length is 0 (write with no data stage). It is 1 when req_length is nonzero and req_type bit 7 is 0 (control write), and 2 when req_length is nonzero and bit 7 is 1 (control read).
- R8: hw_handled is 1 when req_type bits 6:5 are 00 and req_code is 0, 1, 5 or 9. Otherwise it is 0.
- R9: setup_irq pulses for one cycle, together with ack_req, only for an accepted request whose hw_handled is 0.
- R10: setup_irq_flag is set by a setup_irq pulse and cleared by irq_clear. When both happen in the same cycle the flag stays set.
- R11: Data bytes and end-of-packet strobes outside a start-of-packet framed packet change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sop | input | 1 | Start-of-packet strobe (carries no byte) |
| rx_valid | input | 1 | rx_data holds a received byte |
| rx_data | input | 8 | Received data byte |
| rx_eop | input | 1 | End-of-packet strobe (carries no byte) |
| rx_crc_ok | input | 1 | CRC verdict, sampled with rx_eop |
| rx_toggle_ok | input | 1 | Toggle verdict, sampled with rx_eop |
| irq_clear | input | 1 | Clears the sticky interrupt flag |
| req_type | output | 8 | Request-type byte |
| req_code | output | 8 | Request code byte |
| req_value | output | 16 | Value field |
| req_index | output | 16 | Index field |
| req_length | output | 16 | Length field |
| xfer_kind | output | 2 | 0 no data, 1 control write, 2 control read |
| hw_handled | output | 1 | Request is completed in hardware |
| ack_req | output | 1 | One-cycle ACK handshake request |
| setup_irq | output | 1 | One-cycle setup interrupt |
| setup_irq_flag | output | 1 | Sticky setup interrupt flag |
| stage_status | output | 2 | 0 IDLE, 1 DATAIN, 2 RX_ERR |
| data_toggle | output | 1 | Data toggle for the next stage |

## Verification
Setting the sticky interrupt flag and clearing it can land on the same clock edge. The bench provokes this by holding irq_clear high during the end-of-packet cycle of a software-owned request. It judges the result by sampling setup_irq and setup_irq_flag both high in the following cycle, then pulsing irq_clear alone and expecting the flag low. The ACK pulse and the interrupt pulse also coincide by design; every accepted software request checks both in the same sampled cycle.

// File: rtl/usb_setup_pkg.sv
// Package: shared widths, enums and request helpers for the setup-stage handler.
// Assumes requests are little-endian with the request-type byte received first.
package usb_setup_pkg;
    localparam int BYTE_W    = 8;
    localparam int REQ_BYTES = 8;
    localparam int CNT_W     = $clog2(REQ_BYTES + 2);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATAIN = 2'd1,
        ST_RX_ERR = 2'd2
    } stage_status_e;

    typedef enum logic [1:0] {
        XF_NODATA = 2'd0,
        XF_WRITE  = 2'd1,
        XF_READ   = 2'd2
    } xfer_kind_e;

    // Byte i of the packet lands at bits [8i+7:8i]; last member is the LSB.
    typedef struct packed {
        logic [15:0] length;
        logic [15:0] index;
        logic [15:0] value;
        logic [7:0]  code;
        logic [7:0]  rtype;
    } setup_req_t;

    localparam logic [7:0] CODE_GET_STATUS    = 8'd0;
    localparam logic [7:0] CODE_CLEAR_FEATURE = 8'd1;
    localparam logic [7:0] CODE_SET_ADDRESS   = 8'd5;
    localparam logic [7:0] CODE_SET_CONFIG    = 8'd9;

    // True when a request is a standard one that hardware completes alone.
    function automatic logic is_hw_req(input logic [7:0] rtype, input logic [7:0] code);
        logic std;
        std = (rtype[6:5] == 2'b00);
        return std && (code == CODE_GET_STATUS || code == CODE_CLEAR_FEATURE ||
                       code == CODE_SET_ADDRESS || code == CODE_SET_CONFIG);
    endfunction
endpackage

// File: rtl/setup_capture.sv
// Collects the request bytes of a packet into a shadow buffer, counts them,
// and copies the shadow into the visible field registers on commit.
// Assumes rx_sop and rx_eop carry no byte and in_pkt comes from the stage FSM.
module setup_capture
    import usb_setup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_pkt,
    input  logic              rx_sop,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              commit,
    output logic              len_ok,
    output setup_req_t        shadow,
    output setup_req_t        req
);
    logic [CNT_W-1:0] cnt;
    logic [REQ_BYTES-1:0][BYTE_W-1:0] sh_bytes;
    logic take;

    assign take = in_pkt && rx_valid && !rx_sop;

    // Byte counter: restarts on sop, saturates one past the request size.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (rx_sop)
            cnt <= '0;
        else if (take && cnt <= CNT_W'(REQ_BYTES))
            cnt <= cnt + 1'b1;
    end

    // One shadow lane per request byte, written when the counter points at it.
    for (genvar g = 0; g < REQ_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                sh_bytes[g] <= '0;
            else if (take && cnt == CNT_W'(g))
                sh_bytes[g] <= rx_data;
        end
    end

    assign shadow = sh_bytes;
    assign len_ok = (cnt == CNT_W'(REQ_BYTES));

    // Visible field registers: loaded only when the FSM accepts the packet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req <= '0;
        else if (commit)
            req <= shadow;
    end

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(req)); // R4
endmodule

// File: rtl/setup_decode.sv
// Derives transfer type and hardware/software ownership from the accepted request.
// Purely combinational; assumes req is stable between accepted packets.
module setup_decode
    import usb_setup_pkg::*;
(
    input  setup_req_t req,
    output xfer_kind_e xfer_kind,
    output logic       hw_handled
);
    // Transfer type from length and direction bit.
    always_comb begin
        if (req.length == '0)
            xfer_kind = XF_NODATA;
        else if (req.rtype[7])
            xfer_kind = XF_READ;
        else
            xfer_kind = XF_WRITE;
    end

    // Ownership from request-type class bits and request code.
    always_comb hw_handled = is_hw_req(req.rtype, req.code);
endmodule

// File: rtl/setup_stage_fsm.sv
// Tracks packet framing, judges the packet at end of packet, and drives the
// handshake, interrupt, sticky flag, stage status and data toggle.
// Assumes sw_req reflects the shadow request in the end-of-packet cycle.
module setup_stage_fsm
    import usb_setup_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_sop,
    input  logic          rx_eop,
    input  logic          crc_ok,
    input  logic          tog_ok,
    input  logic          len_ok,
    input  logic          sw_req,
    input  logic          irq_clear,
    output logic          in_pkt,
    output logic          commit,
    output logic          ack_req,
    output logic          irq_pulse,
    output logic          irq_flag,
    output stage_status_e stage_status,
    output logic          data_toggle
);
    typedef enum logic {FSM_IDLE, FSM_RECV} fsm_e;
    fsm_e state;
    logic eop_seen, good, bad;

    assign eop_seen = (state == FSM_RECV) && rx_eop && !rx_sop;
    assign good     = eop_seen && len_ok && crc_ok && tog_ok;
    assign bad      = eop_seen && !good;
    assign in_pkt   = (state == FSM_RECV);
    assign commit   = good;

    // Framing state: sop opens a packet, eop closes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= FSM_IDLE;
        else if (rx_sop)
            state <= FSM_RECV;
        else if (rx_eop)
            state <= FSM_IDLE;
    end

    // One-cycle handshake and interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_req   <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            ack_req   <= good;
            irq_pulse <= good && sw_req;
        end
    end

    // Stage status and toggle prepared for the next stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_status <= ST_IDLE;
            data_toggle  <= 1'b0;
        end else if (good) begin
            stage_status <= ST_DATAIN;
            data_toggle  <= 1'b1;
        end else if (bad) begin
            stage_status <= ST_RX_ERR;
        end
    end

    // Sticky interrupt flag; a new interrupt wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_flag <= 1'b0;
        else if (good && sw_req)
            irq_flag <= 1'b1;
        else if (irq_clear)
            irq_flag <= 1'b0;
    end

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> !ack_req); // R3
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> (!ack_req && !irq_pulse && stage_status == ST_RX_ERR)); // R4
    AST_ACK_DATAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> (stage_status == ST_DATAIN && data_toggle)); // R6
    AST_IRQ_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ack_req); // R9
    AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> irq_pulse); // R10
endmodule

// File: rtl/usb_setup_stage.sv
// Top of the SETUP-stage handler: capture, decode and stage FSM.
// Assumes a single control endpoint and an engine that reports CRC and toggle at eop.
module usb_setup_stage
    import usb_setup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sop,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_eop,
    input  logic              rx_crc_ok,
    input  logic              rx_toggle_ok,
    input  logic              irq_clear,
    output logic [7:0]        req_type,
    output logic [7:0]        req_code,
    output logic [15:0]       req_value,
    output logic [15:0]       req_index,
    output logic [15:0]       req_length,
    output logic [1:0]        xfer_kind,
    output logic              hw_handled,
    output logic              ack_req,
    output logic              setup_irq,
    output logic              setup_irq_flag,
    output logic [1:0]        stage_status,
    output logic              data_toggle
);
    setup_req_t    shadow, req;
    logic          in_pkt, commit, len_ok, sw_req;
    xfer_kind_e    kind;
    stage_status_e status;

    // Software ownership judged on the shadow request at end of packet.
    always_comb sw_req = !is_hw_req(shadow.rtype, shadow.code);

    setup_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_pkt   (in_pkt),
        .rx_sop   (rx_sop),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .commit   (commit),
        .len_ok   (len_ok),
        .shadow   (shadow),
        .req      (req)
    );

    setup_decode u_decode (
        .req        (req),
        .xfer_kind  (kind),
        .hw_handled (hw_handled)
    );

    setup_stage_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_sop       (rx_sop),
        .rx_eop       (rx_eop),
        .crc_ok       (rx_crc_ok),
        .tog_ok       (rx_toggle_ok),
        .len_ok       (len_ok),
        .sw_req       (sw_req),
        .irq_clear    (irq_clear),
        .in_pkt       (in_pkt),
        .commit       (commit),
        .ack_req      (ack_req),
        .irq_pulse    (setup_irq),
        .irq_flag     (setup_irq_flag),
        .stage_status (status),
        .data_toggle  (data_toggle)
    );

    assign req_type     = req.rtype;
    assign req_code     = req.code;
    assign req_value    = req.value;
    assign req_index    = req.index;
    assign req_length   = req.length;
    assign xfer_kind    = kind;
    assign stage_status = status;

    AST_HW_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        setup_irq |-> !hw_handled); // R8
endmodule

// File: tb/test_usb_setup_stage.sv
module test_usb_setup_stage;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  rtype;
        logic [7:0]  code;
        logic [15:0] value;
        logic [15:0] index;
        logic [15:0] length;
        logic        crc;
        logic        tog;
        logic        exp_ack;
        logic [1:0]  exp_kind;
        logic        exp_hw;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{8'h80, 8'h06, 16'h0100, 16'h0000, 16'h0012, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0},
        '{8'h00, 8'h05, 16'h0007, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1},
        '{8'h00, 8'h09, 16'h0001, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1},
        '{8'h21, 8'h09, 16'h0200, 16'h0001, 16'h0008, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0},
        '{8'h80, 8'h00, 16'h0000, 16'h0000, 16'h0002, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1},
        '{8'h40, 8'h01, 16'h1234, 16'h5678, 16'h0000, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0},
        '{8'h02, 8'h01, 16'h0000, 16'h0081, 16'h0000, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1},
        '{8'h00, 8'h05, 16'h0009, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1},
        '{8'h00, 8'h09, 16'h0002, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_sop = 1'b0, rx_valid = 1'b0, rx_eop = 1'b0;
    logic rx_crc_ok = 1'b0, rx_toggle_ok = 1'b0, irq_clear = 1'b0;
    logic [7:0] rx_data = '0;
    logic [7:0] req_type, req_code;
    logic [15:0] req_value, req_index, req_length;
    logic [1:0] xfer_kind, stage_status;
    logic hw_handled, ack_req, setup_irq, setup_irq_flag, data_toggle;

    int total = 0, bad = 0;
    logic done = 1'b0;
    logic [63:0] last_good = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_setup_stage i_usb_setup_stage (
        .clk(clk), .rst_n(rst_n), .rx_sop(rx_sop), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_eop(rx_eop), .rx_crc_ok(rx_crc_ok),
        .rx_toggle_ok(rx_toggle_ok), .irq_clear(irq_clear),
        .req_type(req_type), .req_code(req_code), .req_value(req_value),
        .req_index(req_index), .req_length(req_length), .xfer_kind(xfer_kind),
        .hw_handled(hw_handled), .ack_req(ack_req), .setup_irq(setup_irq),
        .setup_irq_flag(setup_irq_flag), .stage_status(stage_status),
        .data_toggle(data_toggle)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] fields();
        return {req_length, req_index, req_value, req_code, req_type};
    endfunction

    function automatic logic [63:0] pack(input vec_t v);
        return {v.length, v.index, v.value, v.code, v.rtype};
    endfunction

    // Sends one packet of n bytes; returns at the negedge after the eop edge.
    task automatic send_pkt(input logic [63:0] bytes, input int n,
                            input logic crc, input logic tog, input logic clr);
        rx_sop = 1'b1;
        @(negedge clk);
        rx_sop = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data  = (i < 8) ? bytes[8*i +: 8] : 8'hAA;
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_eop = 1'b1; rx_crc_ok = crc; rx_toggle_ok = tog; irq_clear = clr;
        @(negedge clk);
        rx_eop = 1'b0; irq_clear = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", 64'(stage_status), 64'd0);
        chk("R1 toggle", 64'(data_toggle), 64'd0);
        chk("R1 fields", fields(), 64'd0);
        chk("R1 pulses", {ack_req, setup_irq, setup_irq_flag}, 64'd0);

        // Table walk: R2 R3 R4 R6 R7 R8 R9 R10
        for (int k = 0; k < NVEC; k++) begin
            vec_t v;
            logic exp_irq;
            v = VECS[k];
            exp_irq = v.exp_ack && !v.exp_hw;
            send_pkt(pack(v), 8, v.crc, v.tog, 1'b0);
            chk("R3 ack", 64'(ack_req), 64'(v.exp_ack));
            chk("R9 irq", 64'(setup_irq), 64'(exp_irq));
            chk("R10 flag set", 64'(setup_irq_flag), 64'(exp_irq));
            chk("R6 toggle", 64'(data_toggle), 64'd1);
            if (v.exp_ack) begin
                last_good = pack(v);
                chk("R2 fields", fields(), last_good);
                chk("R6 status", 64'(stage_status), 64'd1);
                chk("R7 kind", 64'(xfer_kind), 64'(v.exp_kind));
                chk("R8 hw", 64'(hw_handled), 64'(v.exp_hw));
            end else begin
                chk("R4 fields held", fields(), last_good);
                chk("R4 status", 64'(stage_status), 64'd2);
            end
            @(negedge clk);
            chk("R3 ack pulse", {ack_req, setup_irq}, 64'd0);
            irq_clear = 1'b1;
            @(negedge clk);
            irq_clear = 1'b0;
            chk("R10 cleared", 64'(setup_irq_flag), 64'd0);
        end

        // R11: bytes and eop without sop
        for (int i = 0; i < 3; i++) begin
            rx_valid = 1'b1; rx_data = 8'hFF;
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_eop = 1'b1; rx_crc_ok = 1'b1; rx_toggle_ok = 1'b1;
        @(negedge clk);
        rx_eop = 1'b0;
        chk("R11 ack", 64'(ack_req), 64'd0);
        chk("R11 status", 64'(stage_status), 64'd2);
        chk("R11 fields", fields(), last_good);

        // R5: short and long packets with good flags
        send_pkt(pack(VECS[1]), 8, 1'b1, 1'b1, 1'b0);
        last_good = pack(VECS[1]);
        chk("R6 status", 64'(stage_status), 64'd1);
        @(negedge clk);
        send_pkt(64'hFFEE_DDCC_BBAA_9988, 7, 1'b1, 1'b1, 1'b0);
        chk("R5 short ack", 64'(ack_req), 64'd0);
        chk("R5 short status", 64'(stage_status), 64'd2);
        chk("R5 short fields", fields(), last_good);
        @(negedge clk);
        send_pkt(64'h1122_3344_5566_7788, 9, 1'b1, 1'b1, 1'b0);
        chk("R5 long ack", 64'(ack_req), 64'd0);
        chk("R5 long status", 64'(stage_status), 64'd2);
        chk("R5 long fields", fields(), last_good);
        @(negedge clk);

        // R10: clear in the same cycle as a new interrupt; set wins
        send_pkt(pack(VECS[0]), 8, 1'b1, 1'b1, 1'b1);
        chk("R10 same-cycle irq", 64'(setup_irq), 64'd1);
        chk("R10 same-cycle flag", 64'(setup_irq_flag), 64'd1);
        @(negedge clk);
        chk("R10 flag holds", 64'(setup_irq_flag), 64'd1);
        irq_clear = 1'b1;
        @(negedge clk);
        irq_clear = 1'b0;
        chk("R10 clear alone", 64'(setup_irq_flag), 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule